// File: doc/BRIEF.md
# Coherence State Controller for a Single Cache Line

This block tracks the four-state write-invalidate coherence state of one cache line. It holds the state in two bits and moves it on five kinds of event: a read or a write from the local core, a read or a write snooped from the shared bus, and a voluntary writeback (flush) requested by the local side. For each accepted event it reports a hit or a miss, and it raises a request that invalidates other copies when the local core must gain sole ownership. It uses an external "another cache holds this line" response to choose the fill state on a read miss.

Events arrive as a one-hot (or multi-hot) strobe vector that works as the valid side of a valid/ready pair. The requester holds each bit high until the matching bit of the acknowledge vector pulses, and then drops it. The acknowledge acts as ready: it is combinational and one-hot, and it pulses in the same cycle as an event that needs no memory traffic. When a snooped event or a flush finds the line dirty, the controller parks in a pending phase and raises a writeback request from the next cycle on. It holds back every acknowledge until writeback-done is seen, and it acknowledges the parked event in that same cycle. Local events presented meanwhile stall with no acknowledge. The state, writeback request, invalidate, hit and miss pins are plain level or pulse signals.

Top module: `mesi_line_ctrl`

## Requirements
- R1: The state encoding is Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. Reset puts the line in Invalid with no writeback request and no acknowledge.
- R2: A local read (event bit 1) in Modified, Exclusive or Shared is acknowledged in the cycle it is presented, pulses hit_o, and leaves the state unchanged.
- R3: A local write (event bit 2) in Exclusive or Modified is acknowledged at once with hit_o and no invalidate, and ends in Modified. The same event in Shared ends in Modified and pulses inval_o with the acknowledge.
- R4: A local read in Invalid is acknowledged at once with miss_o and ends in Exclusive when shared_i is 0, or in Shared when shared_i is 1.
- R5: A local write in Invalid is acknowledged at once with miss_o and inval_o, and ends in Modified.
- R6: A snooped read (event bit 3) on an Exclusive or Shared line is acknowledged at once and ends in Shared.
- R7: A snooped read or snooped write on a Modified line gets no acknowledge in the cycle it is presented. wb_req_o is high from the next cycle until wb_done_i is seen. The acknowledge pulses in the cycle wb_done_i is high, and the line then ends in Shared (read) or Invalid (write).
- R8: A snooped write (event bit 4) on an Exclusive or Shared line is acknowledged at once and ends in Invalid.
- R9: In Invalid, snooped reads and writes are acknowledged at once, leave the state at Invalid, and raise no writeback request.
- R10: A flush (event bit 0) on a Modified line requests a writeback in the same way as R7 and ends in Exclusive. A flush in any other state is acknowledged at once with no change.
- R11: When several event bits are high, exactly one is acknowledged, picking the highest bit index (snooped write, snooped read, local write, local read, flush).
- R12: While a writeback is pending, no acknowledge is given before wb_done_i, so local events presented meanwhile stall.
- R13: wb_done_i is ignored when no writeback is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 5 | Event strobes: bit0 flush, bit1 local read, bit2 local write, bit3 snooped read, bit4 snooped write |
| shared_i | input | 1 | Another cache holds the line (used on a local read miss) |
| wb_done_i | input | 1 | Writeback to memory completed |
| ack_o | output | 5 | One-hot acknowledge of the accepted event |
| state_o | output | 2 | Current coherence state |
| wb_req_o | output | 1 | Writeback request, high while a writeback is pending |
| inval_o | output | 1 | Pulse: invalidate all other copies |
| hit_o | output | 1 | Pulse: local access found a valid line |
| miss_o | output | 1 | Pulse: local access found the line Invalid |

## Verification
Directed sequences walk the line through every state and apply each event kind in each state. This separates the same-cycle transitions from the paths that wait for a writeback, and separates an Exclusive fill from a Shared fill by the value of shared_i. Writeback waits of zero and of several cycles show whether the acknowledge waits for writeback-done rather than for a fixed delay. Multi-hot strobes presented in the idle phase and during a pending writeback test the priority order and the stalling of local events. Random event streams with random shared responses and waits are then compared with a bench model of the state, acknowledge, hit, miss and invalidate outputs, and a stray writeback-done is applied to check that it has no effect.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  // Two-bit line state; the encoding is visible on state_o.
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  // Event bit positions; a higher index has higher priority.
  localparam int EVN      = 5;
  localparam int EV_FLUSH = 0;
  localparam int EV_LRD   = 1;
  localparam int EV_LWR   = 2;
  localparam int EV_RRD   = 3;
  localparam int EV_RWR   = 4;

  typedef struct packed {
    line_st_e nxt;      // state after the event (after writeback if needed)
    logic     need_wb;  // dirty data must reach memory first
    logic     hit;
    logic     miss;
    logic     inval;
  } step_t;

endpackage

// File: rtl/mesi_evt_pick.sv
module mesi_evt_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);

  // Fixed priority: the highest set index wins.
  logic found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mesi_step_logic.sv
module mesi_step_logic
  import mesi_pkg::*;
(
  input  line_st_e         st_i,
  input  logic [EVN-1:0]   gnt_i,
  input  logic             shared_i,
  output step_t            step_o
);

  always_comb begin
    step_o.nxt     = st_i;
    step_o.need_wb = 1'b0;
    step_o.hit     = 1'b0;
    step_o.miss    = 1'b0;
    step_o.inval   = 1'b0;
    if (gnt_i[EV_LRD]) begin
      if (st_i == ST_I) begin
        step_o.miss = 1'b1;
        step_o.nxt  = shared_i ? ST_S : ST_E;
      end else begin
        step_o.hit = 1'b1;
      end
    end else if (gnt_i[EV_LWR]) begin
      step_o.nxt   = ST_M;
      step_o.miss  = (st_i == ST_I);
      step_o.hit   = (st_i != ST_I);
      step_o.inval = (st_i == ST_I) || (st_i == ST_S);
    end else if (gnt_i[EV_RRD]) begin
      case (st_i)
        ST_M: begin
          step_o.need_wb = 1'b1;
          step_o.nxt     = ST_S;
        end
        ST_E, ST_S: step_o.nxt = ST_S;
        default:    step_o.nxt = ST_I;
      endcase
    end else if (gnt_i[EV_RWR]) begin
      step_o.need_wb = (st_i == ST_M);
      step_o.nxt     = ST_I;
    end else if (gnt_i[EV_FLUSH]) begin
      if (st_i == ST_M) begin
        step_o.need_wb = 1'b1;
        step_o.nxt     = ST_E;
      end
    end
  end

endmodule

// File: rtl/mesi_wb_seq.sv
module mesi_wb_seq #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [N-1:0] gnt_i,
  input  logic         done_i,
  output logic         busy_o,
  output logic [N-1:0] held_o
);

  typedef enum logic {SQ_IDLE = 1'b0, SQ_WAIT = 1'b1} seq_e;
  seq_e sq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      held_o <= '0;
    end else if (sq_q == SQ_IDLE) begin
      if (start_i) begin
        sq_q   <= SQ_WAIT;
        held_o <= gnt_i;
      end
    end else if (done_i) begin
      sq_q   <= SQ_IDLE;
      held_o <= '0;
    end
  end

  assign busy_o = (sq_q == SQ_WAIT);

  // R7: the pending phase is left only through writeback-done
  a_r7_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> busy_o);

  // R7: the parked event is one-hot while waiting
  a_r7_held_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $onehot(held_o));

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     ev_i,
  input  logic           shared_i,
  input  logic           wb_done_i,
  output logic [4:0]     ack_o,
  output logic [1:0]     state_o,
  output logic           wb_req_o,
  output logic           inval_o,
  output logic           hit_o,
  output logic           miss_o
);

  line_st_e       st_q;
  logic [EVN-1:0] gnt;
  logic [EVN-1:0] held;
  logic [EVN-1:0] gnt_eff;
  logic           busy;
  logic           accept;
  logic           start;
  step_t          step;

  mesi_evt_pick #(.N(EVN)) u_pick (
    .req_i (ev_i),
    .gnt_o (gnt)
  );

  assign gnt_eff = busy ? held : gnt;

  mesi_step_logic u_step (
    .st_i     (st_q),
    .gnt_i    (gnt_eff),
    .shared_i (shared_i),
    .step_o   (step)
  );

  assign start  = !busy && (|gnt) && step.need_wb;
  assign accept = busy ? wb_done_i : ((|gnt) && !step.need_wb);

  mesi_wb_seq #(.N(EVN)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .gnt_i   (gnt),
    .done_i  (wb_done_i),
    .busy_o  (busy),
    .held_o  (held)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      st_q <= ST_I;
    else if (accept) st_q <= step.nxt;
  end

  assign ack_o    = accept ? gnt_eff : '0;
  assign hit_o    = accept && step.hit;
  assign miss_o   = accept && step.miss;
  assign inval_o  = accept && step.inval;
  assign wb_req_o = busy;
  assign state_o  = st_q;

  // R1: reset lands in Invalid
  a_r1_reset_invalid: assert property (@(posedge clk)
    !rst_n |=> (st_q == ST_I));

  // R11: never more than one acknowledge
  a_r11_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));

  // R12: nothing is acknowledged while a writeback is outstanding
  a_r12_quiet_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !wb_done_i) |-> (ack_o == '0));

  // R3: an accepted local write leaves the line Modified
  a_r3_write_to_m: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o[EV_LWR] |=> (st_q == ST_M));

  // R8: an accepted snooped write leaves the line Invalid
  a_r8_snoop_write_to_i: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o[EV_RWR] |=> (st_q == ST_I));

  // R6: a snooped read on a valid line ends Shared
  a_r6_snoop_read_to_s: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o[EV_RRD] && st_q != ST_I) |=> (st_q == ST_S));

  // R9: Invalid ignores snooped traffic
  a_r9_invalid_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_I && (ack_o[EV_RRD] || ack_o[EV_RWR])) |=> (st_q == ST_I));

  // R10: flushing a dirty line leaves it Exclusive
  a_r10_flush_to_e: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o[EV_FLUSH] && st_q == ST_M) |=> (st_q == ST_E));

  // R5: an invalidate only accompanies a local write
  a_r5_inval_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    inval_o |-> ack_o[EV_LWR]);

  // R13: a stray writeback-done with no event changes nothing
  a_r13_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_req_o && ev_i == '0) |=> $stable(st_q));

endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  import mesi_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] ev_i;
  logic       shared_i;
  logic       wb_done_i;
  logic [4:0] ack_o;
  logic [1:0] state_o;
  logic       wb_req_o, inval_o, hit_o, miss_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  logic [1:0] exp_st;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .shared_i(shared_i),
    .wb_done_i(wb_done_i), .ack_o(ack_o), .state_o(state_o),
    .wb_req_o(wb_req_o), .inval_o(inval_o), .hit_o(hit_o), .miss_o(miss_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [4:0] ev);
    for (int i = 4; i >= 0; i--) if (ev[i]) return i;
    return -1;
  endfunction

  function automatic bit m_wb(input logic [1:0] st, input int k);
    return st == 2'b11 && (k == 0 || k == 3 || k == 4);
  endfunction

  function automatic logic [1:0] m_next(input logic [1:0] st, input int k, input logic sh);
    case (k)
      1: return (st == 2'b00) ? (sh ? 2'b01 : 2'b10) : st;
      2: return 2'b11;
      3: return (st == 2'b00) ? 2'b00 : 2'b01;
      4: return 2'b00;
      default: return (st == 2'b11) ? 2'b10 : st;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] st, input int k);
    case (k)
      1: return (st == 2'b00) ? "R4" : "R2";
      2: return (st == 2'b00) ? "R5" : "R3";
      3: return (st == 2'b11) ? "R7" : (st == 2'b00) ? "R9" : "R6";
      4: return (st == 2'b11) ? "R7" : (st == 2'b00) ? "R9" : "R8";
      default: return "R10";
    endcase
  endfunction

  // Present an event, complete any writeback after dly cycles, check all pins.
  task automatic do_event(input logic [4:0] ev, input logic sh, input int dly);
    int k;
    string tg;
    @(negedge clk);
    ev_i = ev; shared_i = sh; wb_done_i = 1'b0;
    #1;
    k = pick(ev);
    if (k < 0) begin
      chk("R13", "ack idle", ack_o, 0);
    end else begin
      tg = ($countones(ev) > 1) ? "R11" : req_of(exp_st, k);
      if (m_wb(exp_st, k)) begin
        chk(tg, "ack before writeback", ack_o, 0);
        chk(tg, "wb_req first cycle", wb_req_o, 0);
        @(posedge clk);
        for (int c = 0; c < dly; c++) begin
          @(negedge clk); #1;
          chk("R12", "ack while pending", ack_o, 0);
          chk("R7", "wb_req held", wb_req_o, 1);
        end
        @(negedge clk);
        wb_done_i = 1'b1;
        #1;
        chk(tg, "ack on done", ack_o, 1 << k);
        chk(tg, "wb_req on done", wb_req_o, 1);
      end else begin
        chk(tg, "ack", ack_o, 1 << k);
        chk(tg, "hit", hit_o, (k == 1 || k == 2) && exp_st != 2'b00);
        chk(tg, "miss", miss_o, (k == 1 || k == 2) && exp_st == 2'b00);
        chk(tg, "inval", inval_o, k == 2 && (exp_st == 2'b00 || exp_st == 2'b01));
      end
      exp_st = m_next(exp_st, k, sh);
    end
    @(posedge clk);
    @(negedge clk);
    ev_i = '0; wb_done_i = 1'b0;
    #1;
    chk((k < 0) ? "R13" : req_of(exp_st, k), "state", state_o, exp_st);
    chk("R7", "wb_req idle", wb_req_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] ev;
    void'($urandom(32'd20250));
    rst_n = 1'b0; ev_i = '0; shared_i = 1'b0; wb_done_i = 1'b0;
    exp_st = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "reset state", state_o, 0);
    chk("R1", "reset wb_req", wb_req_o, 0);
    chk("R1", "reset ack", ack_o, 0);
    rst_n = 1'b1;

    do_event(5'b00010, 1'b0, 0);  // I -> E
    do_event(5'b00010, 1'b0, 0);  // hit in E
    do_event(5'b00100, 1'b0, 0);  // E -> M
    do_event(5'b00100, 1'b0, 0);  // M stays
    do_event(5'b01000, 1'b0, 2);  // snooped read on M
    do_event(5'b00100, 1'b0, 0);  // S -> M with inval
    do_event(5'b00001, 1'b0, 1);  // flush M -> E
    do_event(5'b00001, 1'b0, 0);  // flush on E
    do_event(5'b10000, 1'b0, 0);  // E -> I
    do_event(5'b01000, 1'b0, 0);  // ignored in I
    do_event(5'b10000, 1'b0, 0);  // ignored in I
    do_event(5'b00100, 1'b1, 0);  // I -> M
    do_event(5'b10000, 1'b0, 0);  // snooped write on M, zero wait
    do_event(5'b00010, 1'b1, 0);  // I -> S
    do_event(5'b01000, 1'b0, 0);  // S stays
    do_event(5'b10000, 1'b0, 0);  // S -> I
    do_event(5'b00110, 1'b0, 0);  // priority: write over read
    do_event(5'b01011, 1'b0, 3);  // snooped read wins, locals stall
    do_event(5'b00000, 1'b0, 0);

    // Stray writeback-done with no pending writeback
    @(negedge clk);
    wb_done_i = 1'b1; #1;
    chk("R13", "ack on stray done", ack_o, 0);
    @(negedge clk);
    wb_done_i = 1'b0; #1;
    chk("R13", "state after stray done", state_o, exp_st);

    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 7)      ev = 5'b1 << $urandom_range(0, 4);
      else if (r < 9) ev = 5'($urandom_range(1, 31));
      else            ev = '0;
      do_event(ev, 1'($urandom_range(0, 1)), $urandom_range(0, 3));
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule